// File: doc/BRIEF.md
# Three-Axis Inertial Interrupt Generator

This block turns a stream of signed three-axis acceleration samples into an inertial interrupt. A sample set arrives with a one-cycle valid strobe at the output data rate. Each axis is compared against a programmable threshold in both directions. The enabled events are then merged in one of four ways: any enabled event, all enabled events, a change to a new orientation, or a stable orientation.

A sample-counted duration filter decides when a merged condition is accepted. The interrupt is either latched until software reads the source register, or it follows the qualified condition from one sample to the next. Software reads the interrupt cause from an eight-bit source register, and a read strobe clears it.

Top module: `inertial_irq_gen`

## Requirements
- R1: The mode is taken from `cfg_i[7:6]`: 00 selects any-event (OR), 01 selects orientation change, 10 selects all-events (AND) and 11 selects stable orientation. `cfg_i[5:0]` holds the event enables, laid out as ZH=5, ZL=4, YH=3, YL=2, XH=1, XL=0.
- R2: With threshold T, an axis high event is true when the signed sample is at or above +T. An axis low event is true when the sample is at or below -T.
- R3: In OR mode the condition is true when at least one enabled event is true.
- R4: In AND mode the condition is true when every enabled event is true. With no events enabled, the condition is never true.
- R5: In both orientation modes, a direction is known when exactly one axis has a magnitude above T and the direction bit for that axis and sign (same layout as R1) is enabled. In stable-orientation mode the condition is "a known direction". The interrupt stays active for as long as that direction is qualified.
- R6: In orientation-change mode the interrupt is active for one sample period, on the sample where a known direction is qualified and it differs from the last reported direction. The reported direction becomes "unknown" whenever the condition is false, so a return from an unknown state pulses again.
- R7: With duration N, the block accepts the condition on the sample that ends a run of N+1 consecutive true samples, so N=0 means immediate. The run restarts when the condition is false. In orientation modes it also restarts when the direction changes.
- R8: Only bits 6:0 of `ths_i` and of `dur_i` are used. Bit 7 of each has no effect.
- R9: With latching on, an accepted condition sets `irq_o` and captures the source. Both then hold, and the source stays frozen against later events, until a read clears `irq_o` and `src_o` to 0.
- R10: With latching off, `irq_o` and `src_o` are rewritten on every sample. A read without a sample clears `src_o` only.
- R11: In a cycle with neither a sample nor a read, `irq_o` and `src_o` do not change.
- R12: `src_o[7]` is the interrupt-active flag and `src_o[6]` reads 0. In OR and AND mode, bits 5:0 are the enabled events. In orientation modes, they are the enabled direction bit.
- R13: After reset, `irq_o` and `src_o` are 0.
- R14: If a read and a sample fall in the same cycle, the read applies first and the sample result is written over it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | Sample set strobe, one cycle per data-rate period |
| smp_x_i | input | SAMPLE_W | Signed X acceleration |
| smp_y_i | input | SAMPLE_W | Signed Y acceleration |
| smp_z_i | input | SAMPLE_W | Signed Z acceleration |
| cfg_i | input | 8 | Mode bits 7:6 and event enables 5:0 |
| latch_en_i | input | 1 | Latch the interrupt until read |
| ths_i | input | 8 | Threshold, bits 6:0 used |
| dur_i | input | 8 | Duration in samples, bits 6:0 used |
| src_rd_i | input | 1 | Source register read strobe |
| irq_o | output | 1 | Interrupt line |
| src_o | output | 8 | Source register |

## Verification
The bench targets the threshold edges exactly at +T and -T, where an off-by-one compare would either miss the event or fire one count early. It also covers AND mode with no enables, which a naive reduction would make fire on every sample. Orientation-change sequences check the return from an unknown state and a two-axis tie. A design that compares only against the previous sample would miss the first case, and one that picks the largest axis would report a direction during the tie. Further cases cover a duration run broken by one false sample, a latched source that must not be overwritten, bit 7 set on threshold and duration, and a read coinciding with a sample, where the wrong priority would lose an interrupt.

// File: rtl/inertial_pkg.sv
package inertial_pkg;
  localparam int REG_W = 8;
  localparam int N_AXIS = 3;
  localparam int N_EV = 2 * N_AXIS;

  typedef enum logic [1:0] {
    MODE_OR   = 2'b00,
    MODE_MOVE = 2'b01,
    MODE_AND  = 2'b10,
    MODE_POS  = 2'b11
  } mode_e;
endpackage

// File: rtl/inertial_axis_cmp.sv
module inertial_axis_cmp #(
  parameter int SAMPLE_W = 16,
  parameter int THR_W    = 7
) (
  input  logic signed [SAMPLE_W-1:0] smp_i,
  input  logic [THR_W-1:0]           thr_i,
  output logic                       hi_o,
  output logic                       lo_o,
  output logic                       above_o,
  output logic                       pos_o
);
  localparam int CW = SAMPLE_W + 2;

  logic signed [CW-1:0] s_w, t_w, nt_w;

  always_comb begin
    s_w  = CW'(smp_i);
    t_w  = signed'(CW'(thr_i));
    nt_w = -t_w;
    hi_o    = (s_w >= t_w);
    lo_o    = (s_w <= nt_w);
    above_o = (s_w > t_w) || (s_w < nt_w);
    pos_o   = ~smp_i[SAMPLE_W-1];
  end
endmodule

// File: rtl/inertial_combiner.sv
module inertial_combiner
  import inertial_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  mode_e            mode_i,
  input  logic [N_EV-1:0]  en_i,
  input  logic [N_AXIS-1:0] hi_i,
  input  logic [N_AXIS-1:0] lo_i,
  input  logic [N_AXIS-1:0] above_i,
  input  logic [N_AXIS-1:0] pos_i,
  output logic             cond_o,
  output logic [N_EV-1:0]  dir_o,
  output logic [N_EV-1:0]  flags_o
);
  logic [N_EV-1:0] raw_ev, dir_all;
  logic            one_axis, known;

  for (genvar a = 0; a < N_AXIS; a++) begin : g_ev
    assign raw_ev[2*a+1]  = hi_i[a];
    assign raw_ev[2*a]    = lo_i[a];
    assign dir_all[2*a+1] = above_i[a] & pos_i[a];
    assign dir_all[2*a]   = above_i[a] & ~pos_i[a];
  end

  always_comb begin
    one_axis = (above_i == 3'b001) || (above_i == 3'b010) || (above_i == 3'b100);
    dir_o    = one_axis ? (dir_all & en_i) : '0;
    known    = |dir_o;
    unique case (mode_i)
      MODE_OR:  begin cond_o = |(raw_ev & en_i);                         flags_o = raw_ev & en_i; end
      MODE_AND: begin cond_o = (en_i != '0) && ((raw_ev & en_i) == en_i); flags_o = raw_ev & en_i; end
      default:  begin cond_o = known;                                    flags_o = dir_o; end
    endcase
  end

  // R4: AND only when all enabled events present
  p_and_all_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == MODE_AND && cond_o) |-> (en_i != '0) && ((flags_o & en_i) == en_i));
  // R5: at most one direction reported
  p_dir_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $onehot0(dir_o));
endmodule

// File: rtl/inertial_dur_qual.sv
module inertial_dur_qual
  import inertial_pkg::*;
#(
  parameter int DUR_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            is_6d_i,
  input  logic            is_move_i,
  input  logic            cond_i,
  input  logic [N_EV-1:0] dir_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic            act_o
);
  localparam int CNT_W = DUR_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1) << DUR_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [N_EV-1:0]  prev_dir_q, rep_dir_q;
  logic             run_cont, qual;

  always_comb begin
    run_cont = is_6d_i ? (dir_i == prev_dir_q) : 1'b1;
    if (!cond_i)                       cnt_d = '0;
    else if (!run_cont)                cnt_d = CNT_W'(1);
    else if (cnt_q >= CNT_MAX)         cnt_d = CNT_MAX;
    else                               cnt_d = cnt_q + CNT_W'(1);
    qual  = cond_i && (cnt_d > CNT_W'(dur_i));
    act_o = is_move_i ? (qual && (dir_i != rep_dir_q)) : qual;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      prev_dir_q <= '0;
      rep_dir_q  <= '0;
    end else if (valid_i) begin
      cnt_q      <= cnt_d;
      prev_dir_q <= cond_i ? dir_i : '0;
      if (!cond_i)   rep_dir_q <= '0;
      else if (qual) rep_dir_q <= dir_i;
    end
  end

  // R7: a false sample restarts the run
  p_dur_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cond_i) |=> (cnt_q == '0));
  // R7: no activity without the condition
  p_act_cond_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && act_o) |-> cond_i);
  // R6: a reported movement records its direction
  p_move_rep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_move_i && act_o) |=> (rep_dir_q == $past(dir_i)));
endmodule

// File: rtl/inertial_irq_gen.sv
module inertial_irq_gen
  import inertial_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int THS_W     = 7,
  parameter int DUR_W     = 7,
  parameter int THS_SHIFT = 0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       smp_valid_i,
  input  logic signed [SAMPLE_W-1:0] smp_x_i,
  input  logic signed [SAMPLE_W-1:0] smp_y_i,
  input  logic signed [SAMPLE_W-1:0] smp_z_i,
  input  logic [REG_W-1:0]           cfg_i,
  input  logic                       latch_en_i,
  input  logic [REG_W-1:0]           ths_i,
  input  logic [REG_W-1:0]           dur_i,
  input  logic                       src_rd_i,
  output logic                       irq_o,
  output logic [REG_W-1:0]           src_o
);
  localparam int THR_W = THS_W + THS_SHIFT;

  mode_e                    mode;
  logic [N_EV-1:0]          en;
  logic [THR_W-1:0]         thr;
  logic signed [SAMPLE_W-1:0] smp_a [N_AXIS];
  logic [N_AXIS-1:0]        hi, lo, above, pos;
  logic                     cond, act, latched_hold;
  logic [N_EV-1:0]          dir, flags;
  logic                     irq_q;
  logic [REG_W-1:0]         src_q, src_new;
  logic                     unused_bits;

  assign mode        = mode_e'(cfg_i[7:6]);
  assign en          = cfg_i[N_EV-1:0];
  assign thr         = THR_W'(ths_i[THS_W-1:0]) << THS_SHIFT;
  assign unused_bits = ^{ths_i[REG_W-1:THS_W], dur_i[REG_W-1:DUR_W]};
  assign smp_a[0]    = smp_x_i;
  assign smp_a[1]    = smp_y_i;
  assign smp_a[2]    = smp_z_i;

  for (genvar a = 0; a < N_AXIS; a++) begin : g_axis
    inertial_axis_cmp #(.SAMPLE_W(SAMPLE_W), .THR_W(THR_W)) u_cmp (
      .smp_i   (smp_a[a]),
      .thr_i   (thr),
      .hi_o    (hi[a]),
      .lo_o    (lo[a]),
      .above_o (above[a]),
      .pos_o   (pos[a])
    );
  end

  inertial_combiner u_comb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (smp_valid_i),
    .mode_i  (mode),
    .en_i    (en),
    .hi_i    (hi),
    .lo_i    (lo),
    .above_i (above),
    .pos_i   (pos),
    .cond_o  (cond),
    .dir_o   (dir),
    .flags_o (flags)
  );

  inertial_dur_qual #(.DUR_W(DUR_W)) u_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (smp_valid_i),
    .is_6d_i   (cfg_i[6]),
    .is_move_i (mode == MODE_MOVE),
    .cond_i    (cond),
    .dir_i     (dir),
    .dur_i     (dur_i[DUR_W-1:0]),
    .act_o     (act)
  );

  assign src_new      = {act, 1'b0, flags};
  assign latched_hold = irq_q && !src_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      src_q <= '0;
    end else if (smp_valid_i) begin
      if (!latch_en_i) begin
        irq_q <= act;
        src_q <= src_new;
      end else if (act) begin
        irq_q <= 1'b1;
        if (!latched_hold) src_q <= src_new;
      end else if (src_rd_i) begin
        irq_q <= 1'b0;
        src_q <= '0;
      end
    end else if (src_rd_i) begin
      src_q <= '0;
      if (latch_en_i) irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;
  assign src_o = src_q;

  // R12: reserved bit reads zero
  p_src_rsvd_r12: assert property (@(posedge clk_i) disable iff (!rst_ni) src_o[6] == 1'b0);
  // R12: a new interrupt shows in the active flag
  p_irq_flag_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> src_o[7]);
  // R11: idle cycles change nothing
  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smp_valid_i && !src_rd_i) |=> ($stable(irq_o) && $stable(src_o)));
  // R9: a read without a sample clears the source
  p_read_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_rd_i && !smp_valid_i) |=> (src_o == '0));
  // R9: latched interrupt holds until read
  p_latch_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_en_i && irq_o && !src_rd_i) |=> irq_o);
endmodule

// File: tb/inertial_irq_gen_tb_top.sv
module inertial_irq_gen_tb_top;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, latch = 1'b0, rd = 1'b0;
  logic signed [SW-1:0] sx = '0, sy = '0, sz = '0;
  logic [7:0] cfg = '0, ths = '0, dur = '0;
  logic irq;
  logic [7:0] src;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // model state
  int m_cnt;
  logic [5:0] m_prev, m_rep;
  logic m_irq;
  logic [7:0] m_src;

  always #4 clk = ~clk;

  inertial_irq_gen #(.SAMPLE_W(SW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(valid),
    .smp_x_i(sx), .smp_y_i(sy), .smp_z_i(sz),
    .cfg_i(cfg), .latch_en_i(latch), .ths_i(ths), .dur_i(dur),
    .src_rd_i(rd), .irq_o(irq), .src_o(src)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic model_step();
    int t, s[3], cnt_n;
    logic [5:0] raw, dall, dirm, en, flg;
    logic [2:0] ab;
    logic one, cond, qual, act, is6, mv;
    t  = int'(ths[6:0]);
    s[0] = int'(sx); s[1] = int'(sy); s[2] = int'(sz);
    en = cfg[5:0];
    for (int a = 0; a < 3; a++) begin
      raw[2*a+1]  = (s[a] >= t);
      raw[2*a]    = (s[a] <= -t);
      ab[a]       = (s[a] > t) || (s[a] < -t);
      dall[2*a+1] = ab[a] && (s[a] > 0);
      dall[2*a]   = ab[a] && (s[a] < 0);
    end
    one  = (ab == 3'b001) || (ab == 3'b010) || (ab == 3'b100);
    dirm = one ? (dall & en) : 6'd0;
    is6  = cfg[6];
    mv   = (cfg[7:6] == 2'b01);
    case (cfg[7:6])
      2'b00: begin cond = |(raw & en); flg = raw & en; end
      2'b10: begin cond = (en != 0) && ((raw & en) == en); flg = raw & en; end
      default: begin cond = (dirm != 0); flg = dirm; end
    endcase
    if (!valid) begin
      if (rd) begin
        m_src = 8'h00;
        if (latch) m_irq = 1'b0;
      end
      return;
    end
    if (!cond) cnt_n = 0;
    else if (is6 && dirm != m_prev) cnt_n = 1;
    else cnt_n = (m_cnt >= 128) ? 128 : m_cnt + 1;
    qual = cond && (cnt_n > int'(dur[6:0]));
    act  = mv ? (qual && dirm != m_rep) : qual;
    m_cnt  = cnt_n;
    m_prev = cond ? dirm : 6'd0;
    if (!cond) m_rep = 6'd0;
    else if (qual) m_rep = dirm;
    if (!latch) begin
      m_irq = act;
      m_src = {act, 1'b0, flg};
    end else if (act) begin
      if (!(m_irq && !rd)) m_src = {1'b1, 1'b0, flg};
      m_irq = 1'b1;
    end else if (rd) begin
      m_irq = 1'b0;
      m_src = 8'h00;
    end
  endtask

  task automatic check(input string tag, input logic exp_irq, input logic [7:0] exp_src);
    checks++;
    if (irq !== exp_irq || src !== exp_src) begin
      errors++;
      $display("FAIL %s irq=%0b src=%02h expected irq=%0b src=%02h", tag, irq, src, exp_irq, exp_src);
    end
  endtask

  task automatic step(input logic v, input int x, input int y, input int z, input logic r,
                      input string tag);
    @(negedge clk);
    valid = v; rd = r;
    sx = SW'(x); sy = SW'(y); sz = SW'(z);
    model_step();
    @(posedge clk);
    #1;
    check(tag, m_irq, m_src);
    @(negedge clk);
    valid = 1'b0; rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; valid = 1'b0; rd = 1'b0;
    m_cnt = 0; m_prev = 0; m_rep = 0; m_irq = 0; m_src = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int mode_sel, span;
    string tg;
    void'($urandom(32'd4242));
    do_reset();
    #1;
    check("R13 reset", 1'b0, 8'h00);

    // R2 R3 R8: OR on XH, bit 7 of threshold and duration set
    latch = 0; cfg = 8'h02; ths = 8'h94; dur = 8'h80;
    step(1, 20, 0, 0, 0, "R2 hi at +T");   check("R8 ths/dur bit7", 1'b1, 8'h82);
    step(1, 19, 0, 0, 0, "R2 below +T");   check("R3 OR off", 1'b0, 8'h00);
    cfg = 8'h01;
    step(1, -20, 0, 0, 0, "R2 lo at -T");  check("R2 lo flag", 1'b1, 8'h81);
    step(1, -19, 0, 0, 0, "R2 above -T");  check("R2 lo off", 1'b0, 8'h00);

    // R4 AND
    do_reset(); cfg = 8'h8A; ths = 8'd20; dur = 8'd0;
    step(1, 30, 5, 0, 0, "R4 partial");    check("R4 partial", 1'b0, 8'h02);
    step(1, 30, 30, 0, 0, "R4 all");       check("R4 all", 1'b1, 8'h8A);
    cfg = 8'h80;
    step(1, 100, 100, 100, 0, "R4 none");  check("R4 no enables", 1'b0, 8'h00);

    // R5 stable orientation
    do_reset(); cfg = 8'hFF;
    step(1, 0, 0, 50, 0, "R5 known");      check("R5 known ZH", 1'b1, 8'hA0);
    step(1, 0, 0, 50, 0, "R5 held");       check("R5 held", 1'b1, 8'hA0);
    step(1, 50, 0, 50, 0, "R5 tie");       check("R5 two axes", 1'b0, 8'h00);

    // R6 orientation change
    do_reset(); cfg = 8'h7F;
    step(1, 100, 0, 0, 0, "R6 first");     check("R6 pulse XH", 1'b1, 8'h82);
    step(1, 100, 0, 0, 0, "R6 same");      check("R6 one period", 1'b0, 8'h02);
    step(1, 0, 0, -50, 0, "R6 change");    check("R6 pulse ZL", 1'b1, 8'h90);
    step(1, 0, 0, 0, 0, "R6 unknown");     check("R6 unknown", 1'b0, 8'h00);
    step(1, 0, 0, -50, 0, "R6 return");    check("R6 from unknown", 1'b1, 8'h90);

    // R7 duration
    do_reset(); cfg = 8'h02; dur = 8'd2;
    step(1, 30, 0, 0, 0, "R7 s1");         check("R7 run 1", 1'b0, 8'h02);
    step(1, 30, 0, 0, 0, "R7 s2");         check("R7 run 2", 1'b0, 8'h02);
    step(1, 30, 0, 0, 0, "R7 s3");         check("R7 run 3", 1'b1, 8'h82);
    step(1, 0, 0, 0, 0, "R7 break");       check("R7 break", 1'b0, 8'h00);
    step(1, 30, 0, 0, 0, "R7 restart");    check("R7 restart", 1'b0, 8'h02);

    // R9 R11 R14 latching
    do_reset(); latch = 1; cfg = 8'h02; dur = 8'd0;
    step(1, 30, 0, 0, 0, "R9 set");        check("R9 set", 1'b1, 8'h82);
    step(1, 0, 0, 0, 0, "R9 hold");        check("R9 hold", 1'b1, 8'h82);
    step(0, 99, 99, 99, 0, "R11 idle");    check("R11 idle", 1'b1, 8'h82);
    cfg = 8'h01;
    step(1, -30, 0, 0, 0, "R9 frozen");    check("R9 frozen", 1'b1, 8'h82);
    step(0, 0, 0, 0, 1, "R9 read");        check("R9 read clear", 1'b0, 8'h00);
    step(1, -30, 0, 0, 1, "R14 rd+smp");   check("R14 sample wins", 1'b1, 8'h81);

    // R10 non-latched read
    latch = 0; cfg = 8'h02;
    step(1, 30, 0, 0, 0, "R10 set");      check("R10 follows", 1'b1, 8'h82);
    step(0, 0, 0, 0, 1, "R10 read");      check("R10 read src only", 1'b1, 8'h00);
    step(0, 0, 0, 0, 0, "R11 idle nl");   check("R11 idle nl", 1'b1, 8'h00);

    // R1 R12: random modes against the model
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      if (i % 150 == 0) begin
        cfg   = 8'($urandom);
        ths   = 8'($urandom_range(0, 255));
        dur   = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 3));
        latch = 1'($urandom);
      end
      span = int'(ths[6:0]) + 30;
      mode_sel = int'(cfg[7:6]);
      case (mode_sel)
        0: tg = "R1 R3 rand OR";
        1: tg = "R1 R6 rand move";
        2: tg = "R1 R4 rand AND";
        default: tg = "R1 R5 rand pos";
      endcase
      step($urandom_range(0, 9) < 7,
           $urandom_range(0, 2*span) - span,
           $urandom_range(0, 2*span) - span,
           $urandom_range(0, 2*span) - span,
           $urandom_range(0, 9) == 0, tg);
      checks++;
      if (src[6] !== 1'b0) begin
        errors++;
        $display("FAIL R12 src[6]=%0b expected 0", src[6]);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule